// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short byte queue of instruction bytes filled ahead of an execution stage. The fetch side holds a sequential prefetch address. It raises a word read request toward a 16-bit memory port whenever the queue has room for a full word, and it appends the returned bytes to the tail of the queue. On the other side, the execution stage removes one byte per cycle from the head, on its own schedule. The only points where one side waits for the other are a full queue and an empty queue.

When the execution stage changes the flow of control, it asserts a flush together with the new target address. The flush empties the queue, drops any word returned in that same cycle, and restarts prefetching from the target. If the prefetch address is odd, a fetch delivers only the upper byte of the returned word. The address then steps by one, so every fetch after that starts on an even address.

The memory port uses a request/acknowledge handshake. The request and its address stay steady until the memory acknowledges, and the read word arrives in the same cycle as the acknowledge.

Top module: `pfq_top`

## Requirements
- R1: While rst_n is low at a clock edge, the queue becomes empty (level 0, pop_valid 0) and the prefetch address becomes RESET_ADDR (0 by default).
- R2: req is high exactly when the queue holds at most DEPTH-2 bytes and flush is low. While no acknowledge and no flush occur, req_addr holds its value.
- R3: An acknowledge at an even req_addr appends ack_data[7:0] and then ack_data[15:8] to the queue, and advances req_addr by 2.
- R4: An acknowledge at an odd req_addr appends only ack_data[15:8], and advances req_addr by 1, so that the next fetch address is even.
- R5: pop_byte shows the oldest byte in the queue whenever pop_valid is high, and pop_valid is high exactly when level is nonzero. A pop removes that byte.
- R6: A pop while the queue is empty is ignored and does not change the level or the byte order.
- R7: When a push and a pop happen in the same cycle, the level changes by the number of bytes pushed minus one, and first-in first-out order is preserved.
- R8: A flush empties the queue at the next clock edge and loads req_addr from flush_addr. Any acknowledge or pop in the flush cycle is discarded.
- R9: The level never exceeds DEPTH (6 by default). With a slow consumer, fetching continues until the queue is full or one byte short of full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties the queue and redirects prefetching |
| flush_addr | input | AW | New prefetch address, loaded on flush |
| req | output | 1 | Word fetch request to memory |
| req_addr | output | AW | Byte address of the fetch |
| ack | input | 1 | Memory acknowledge; ack_data is valid with it |
| ack_data | input | 16 | Returned word, lower-addressed byte in bits 7:0 |
| pop | input | 1 | Execution side removes the head byte |
| pop_valid | output | 1 | The queue holds at least one byte |
| pop_byte | output | 8 | Head byte of the queue |
| level | output | $clog2(DEPTH+1) | Number of bytes held |

## Verification
The assertions take for granted that ack is asserted only while req is high, and that ack_data carries the word at the current req_addr, with the even-addressed byte in the low half. pop may arrive in any cycle, including when the queue is empty. The bench derives ack from its own model of req and builds ack_data from a fixed address-to-byte function. It sweeps every pairing of pop rate and acknowledge rate, and inserts flushes to both odd and even targets, so the handshake assumption always holds.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch byte queue.
// Assumes a 16-bit memory word made of two 8-bit bytes, little-endian.
package pfq_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } word_t;
endpackage

// File: rtl/pfq_store.sv
// Circular byte store with a two-byte push port and a one-byte pop port.
// Assumes the caller pushes only when at least push_n slots are free.
// A pop on an empty store is dropped. clr empties the store and overrides
// any push or pop in the same cycle.
module pfq_store #(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [1:0]           push_n,
    input  pfq_pkg::byte_t       push_b0,
    input  pfq_pkg::byte_t       push_b1,
    input  logic                 pop,
    output pfq_pkg::byte_t       head,
    output logic [CW-1:0]        count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pfq_pkg::byte_t  mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic            pop_ok;

    // Advance a pointer by n and wrap it at DEPTH.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [1:0] n);
        logic [PW:0] s;
        s = {1'b0, p} + (PW+1)'(n);
        if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
        return s[PW-1:0];
    endfunction

    // A pop is taken only when a byte is present and no clear is pending.
    assign pop_ok = pop && (count != '0) && !clr;
    assign head   = mem[rd_ptr];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok)         rd_ptr <= step(rd_ptr, 2'd1);
            if (push_n != 2'd0) wr_ptr <= step(wr_ptr, push_n);
            count <= CW'(count + CW'(push_n) - CW'(pop_ok));
        end
    end

    // Byte storage writes, first byte at the tail, second just after it.
    always_ff @(posedge clk) begin
        if (!clr && push_n != 2'd0) mem[wr_ptr] <= push_b0;
        if (!clr && push_n == 2'd2) mem[step(wr_ptr, 2'd1)] <= push_b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R9

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && push_n == 2'd0 && !clr) |=> (count == '0)); // R6

    AST_POP_HEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !clr && push_n == 2'd0) |=> (count == $past(count) - 1'b1)); // R5
endmodule

// File: rtl/pfq_fetch.sv
// Prefetch address counter and word request logic.
// Requests a word while at least two slots are free and no flush is present.
// Assumes ack arrives only while req is high, with the word for req_addr.
// An odd address fetches only the upper byte, which realigns the address.
module pfq_fetch #(
    parameter int          AW         = 16,
    parameter int          DEPTH      = 6,
    parameter int          CW         = $clog2(DEPTH + 1),
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [AW-1:0]   flush_addr,
    input  logic [CW-1:0]   count,
    input  logic            ack,
    input  pfq_pkg::word_t  ack_data,
    output logic            req,
    output logic [AW-1:0]   req_addr,
    output logic [1:0]      push_n,
    output pfq_pkg::byte_t  push_b0,
    output pfq_pkg::byte_t  push_b1
);
    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - 2);

    logic take;
    logic odd;

    // Request while a whole word fits; a flush cycle never requests.
    assign req  = (count <= ROOM_LIMIT) && !flush;
    assign take = req && ack;
    assign odd  = req_addr[0];

    // Route returned bytes: an odd fetch keeps only the upper byte.
    always_comb begin
        push_n  = take ? (odd ? 2'd1 : 2'd2) : 2'd0;
        push_b0 = odd ? ack_data.hi : ack_data.lo;
        push_b1 = ack_data.hi;
    end

    // Prefetch address: reset value, flush target, or step by bytes taken.
    always_ff @(posedge clk) begin
        if (!rst_n)     req_addr <= RESET_ADDR;
        else if (flush) req_addr <= flush_addr;
        else if (take)  req_addr <= req_addr + (odd ? AW'(1) : AW'(2));
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !flush) |=> $stable(req_addr)); // R2

    AST_ODD_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && odd && !flush) |=> !req_addr[0]); // R4

    AST_EVEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !odd && !flush) |=> !req_addr[0]); // R3

    AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (req_addr == $past(flush_addr))); // R8
endmodule

// File: rtl/pfq_top.sv
// Instruction prefetch byte queue: word fetches in, single bytes out.
// Joins the fetch counter and the byte store. Assumes memory answers
// the current req_addr with ack while req is high.
module pfq_top #(
    parameter int            DEPTH      = 6,
    parameter int            AW         = 16,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [AW-1:0]                flush_addr,
    output logic                         req,
    output logic [AW-1:0]                req_addr,
    input  logic                         ack,
    input  logic [15:0]                  ack_data,
    input  logic                         pop,
    output logic                         pop_valid,
    output logic [7:0]                   pop_byte,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]      push_n;
    pfq_pkg::byte_t  push_b0;
    pfq_pkg::byte_t  push_b1;
    pfq_pkg::byte_t  head;

    pfq_fetch #(
        .AW(AW), .DEPTH(DEPTH), .CW(CW), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .count(level), .ack(ack), .ack_data(pfq_pkg::word_t'(ack_data)),
        .req(req), .req_addr(req_addr),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
    );

    pfq_store #(
        .DEPTH(DEPTH), .CW(CW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop(pop), .head(head), .count(level)
    );

    // Head byte is presented whenever the queue is not empty.
    assign pop_valid = (level != '0);
    assign pop_byte  = head;

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0)); // R8

    AST_REQ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (level <= CW'(DEPTH - 2))); // R2

    AST_NET_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && pop && level != '0 && !flush && !req_addr[0])
        |=> (level == $past(level) + 1'b1)); // R7
endmodule

// File: tb/test_pfq_top.sv
// Sweeps pop rate against acknowledge rate with periodic flushes, and
// compares every output against a byte-queue model each cycle.
module test_pfq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;
    localparam int AW         = 16;

    logic          clk;
    logic          rst_n;
    logic          flush;
    logic [AW-1:0] flush_addr;
    logic          req;
    logic [AW-1:0] req_addr;
    logic          ack;
    logic [15:0]   ack_data;
    logic          pop;
    logic          pop_valid;
    logic [7:0]    pop_byte;
    logic [2:0]    level;

    pfq_top #(.DEPTH(DEPTH), .AW(AW)) i_pfq_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .req(req), .req_addr(req_addr), .ack(ack), .ack_data(ack_data),
        .pop(pop), .pop_valid(pop_valid), .pop_byte(pop_byte), .level(level)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]    mq[$];
    logic [AW-1:0] maddr;
    string         tag;

    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return 8'(a * 5 + (a >> 8) + 3);
    endfunction

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit exp_req;
        rst_n = 1'b0; flush = 1'b0; flush_addr = '0;
        ack = 1'b0; ack_data = '0; pop = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(level == 3'd0, "R1", int'(level), 0);
        chk(pop_valid == 1'b0, "R1", int'(pop_valid), 0);
        chk(req_addr == '0, "R1", int'(req_addr), 0);
        rst_n = 1'b1;
        maddr = '0;
        tag = "R3";
        for (int p = 1; p <= 4; p++) begin
            for (int a = 1; a <= 3; a++) begin
                for (int cyc = 0; cyc < 300; cyc++) begin
                    int sz;
                    sz = mq.size();
                    flush      = ((cyc % 41) == 40);
                    flush_addr = AW'(cyc * 13 + p * a);
                    pop        = ((cyc % p) == 0);
                    exp_req    = ((DEPTH - sz) >= 2) && !flush;
                    ack        = exp_req && ((cyc % a) == 0);
                    ack_data   = {mb(maddr | AW'(1)), mb(maddr & ~AW'(1))};
                    #1;
                    chk(req == exp_req, (sz >= DEPTH - 1) ? "R9" : "R2", int'(req), int'(exp_req));
                    chk(req_addr == maddr, tag, int'(req_addr), int'(maddr));
                    chk(level == 3'(sz), tag, int'(level), sz);
                    chk(pop_valid == (sz != 0), "R5", int'(pop_valid), int'(sz != 0));
                    if (sz != 0) chk(pop_byte == mq[0], "R5", int'(pop_byte), int'(mq[0]));
                    // model update for the coming edge
                    if (flush) begin
                        mq.delete();
                        maddr = flush_addr;
                        tag = "R8";
                    end else begin
                        bit popped;
                        bit pushed;
                        popped = pop && sz != 0;
                        pushed = ack;
                        if (popped) void'(mq.pop_front());
                        if (pop && sz == 0) tag = "R6";
                        else if (popped && pushed) tag = "R7";
                        else if (pushed && maddr[0]) tag = "R4";
                        else if (pushed) tag = "R3";
                        else tag = "R5";
                        if (pushed) begin
                            if (maddr[0]) begin
                                mq.push_back(mb(maddr));
                                maddr = maddr + AW'(1);
                            end else begin
                                mq.push_back(mb(maddr));
                                mq.push_back(mb(maddr + AW'(1)));
                                maddr = maddr + AW'(2);
                            end
                        end
                    end
                    @(negedge clk);
                end
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule